// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a memory-mapped watchdog for a system that must prove it is still running. It counts an external slow tick, normally 1 kHz, while it is enabled. When the count reaches a programmed limit before software has serviced it, the block raises a reset request. Software services the timer by writing a refresh key to the count register. Writing any other value there has no effect.

The configuration is protected in two ways. The control word and the limit register accept a write only during a short window that a separate unlock key opens. Once software commits a control word with the reconfiguration permission cleared, the configuration is frozen until the next hardware reset. Keys are written either as a single 32-bit word or as two 16-bit halves in a fixed order, depending on a mode bit in the control word.

With a 1 kHz tick a limit of seconds × 1000 gives the timeout. The default 17-bit limit holds every value from 1 s to 128 s.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control word reads 0x0000_0020 (update permitted, disabled, 16-bit key mode), the count reads 0, the limit reads INIT_TIMEOUT (1000) and resetReq is low.
- R2: Register map: control at offset 0x0, count at 0x4, limit at 0x8. Control fields: bit 7 enable, bit 5 update permission, bit 13 32-bit key mode, bit 11 unlocked (read-only), bit 10 reconfigured (read-only). All other bits read 0.
- R3: A write to the control or limit register has no effect unless the unlocked bit is set.
- R4: In 16-bit key mode, two writes to the count register, 0x0000_C520 and then 0x0000_D928, set the unlocked bit.
- R5: In 32-bit key mode, a single write of 0xD928_C520 unlocks and a single write of 0xB480_A602 refreshes. The 16-bit halves do nothing in this mode.
- R6: An unlock opens a window of WINDOW (256) bus clock cycles. A configuration write in the 256th cycle after the key write is accepted and one in the 257th is not. An accepted control write closes the window and sets bit 10.
- R7: A count-register write that matches no expected key value, including a wrong second half, is ignored. It also clears any half-matched sequence and leaves the count unchanged.
- R8: Once a control word with bit 5 clear has been committed, unlock keys are ignored until reset, so the configuration cannot change.
- R9: While bit 7 is set, each tick increments the count. While it is clear, the count holds. A refresh (0x0000_A602 then 0x0000_B480 in 16-bit mode) sets the count to 0.
- R10: On the tick that brings the count to the limit, resetReq rises. It falls on the next tick. After that the count holds and refresh keys are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle count strobe, typically 1 kHz |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| resetReq | output | 1 | Reset request to the system |

## Verification
The bench sweeps limits 1 to 6 and checks the exact tick on which the request rises. A design that fired one tick early or late, or that kept counting after it fired, would fail there. It probes the unlock window at the 256th and 257th cycles, where an off-by-one counter would accept or reject the wrong write. It also checks broken, reversed and wrong-mode key sequences and a refresh attempt after the timer has fired, which a loose key decoder would wrongly accept. A frozen configuration must reject a later unlock, and a design that kept honouring the update bit after commit would let the limit change.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int DATA_W = 32;

  localparam logic [3:0] OFF_CTRL  = 4'h0;
  localparam logic [3:0] OFF_COUNT = 4'h4;
  localparam logic [3:0] OFF_LIMIT = 4'h8;

  localparam int BIT_EN    = 7;
  localparam int BIT_UPD   = 5;
  localparam int BIT_MODE  = 13;
  localparam int BIT_OPEN  = 11;
  localparam int BIT_DONE  = 10;

  localparam logic [31:0] KEY_OPEN_32  = 32'hD928_C520;
  localparam logic [31:0] KEY_FEED_32  = 32'hB480_A602;
  localparam logic [15:0] KEY_OPEN_LO  = 16'hC520;
  localparam logic [15:0] KEY_OPEN_HI  = 16'hD928;
  localparam logic [15:0] KEY_FEED_LO  = 16'hA602;
  localparam logic [15:0] KEY_FEED_HI  = 16'hB480;

  typedef enum logic [1:0] {
    HALF_NONE,
    HALF_OPEN,
    HALF_FEED
  } halfState_t;

  typedef struct packed {
    logic refresh;
    logic loadLimit;
    logic enable;
  } kwdStrobes_t;
endpackage

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WINDOW = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output kwdStrobes_t       stb,
  output logic [31:0]       ctrlWord
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  logic             enQ, updQ, modeQ, doneQ;
  logic [WIN_W-1:0] winQ;
  halfState_t       halfQ;

  logic unlocked, frozen, keyWr, ctrlWr, limitWr;
  logic openHit, feedHit;

  assign unlocked = (winQ != '0);
  assign frozen   = doneQ && !updQ;
  assign keyWr    = busWe && (busAddr == ADDR_W'(OFF_COUNT));
  assign ctrlWr   = busWe && (busAddr == ADDR_W'(OFF_CTRL)) && unlocked;
  assign limitWr  = busWe && (busAddr == ADDR_W'(OFF_LIMIT)) && unlocked;

  always_comb begin
    if (modeQ) begin
      openHit = keyWr && (busWdata == KEY_OPEN_32);
      feedHit = keyWr && (busWdata == KEY_FEED_32);
    end else begin
      openHit = keyWr && (halfQ == HALF_OPEN) && (busWdata == {16'h0, KEY_OPEN_HI});
      feedHit = keyWr && (halfQ == HALF_FEED) && (busWdata == {16'h0, KEY_FEED_HI});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halfQ <= HALF_NONE;
    end else if (keyWr) begin
      if (!modeQ && halfQ == HALF_NONE && busWdata == {16'h0, KEY_OPEN_LO})
        halfQ <= HALF_OPEN;
      else if (!modeQ && halfQ == HALF_NONE && busWdata == {16'h0, KEY_FEED_LO})
        halfQ <= HALF_FEED;
      else
        halfQ <= HALF_NONE;
    end else if (modeQ) begin
      halfQ <= HALF_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winQ <= '0;
    end else if (openHit && !frozen) begin
      winQ <= WIN_W'(WINDOW);
    end else if (ctrlWr) begin
      winQ <= '0;
    end else if (unlocked) begin
      winQ <= winQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enQ   <= 1'b0;
      updQ  <= 1'b1;
      modeQ <= 1'b0;
      doneQ <= 1'b0;
    end else if (ctrlWr) begin
      enQ   <= busWdata[BIT_EN];
      updQ  <= busWdata[BIT_UPD];
      modeQ <= busWdata[BIT_MODE];
      doneQ <= 1'b1;
    end
  end

  assign stb.refresh   = feedHit;
  assign stb.loadLimit = limitWr;
  assign stb.enable    = enQ;

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[BIT_EN]   = enQ;
    ctrlWord[BIT_UPD]  = updQ;
    ctrlWord[BIT_MODE] = modeQ;
    ctrlWord[BIT_OPEN] = unlocked;
    ctrlWord[BIT_DONE] = doneQ;
  end

  // R8
  frozen_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !unlocked);

  // R6
  window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWr && !openHit) |=> !unlocked);

  // R3
  closed_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable({enQ, updQ, modeQ}));
endmodule

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int LIMIT_W      = 17,
  parameter int INIT_TIMEOUT = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  kwdStrobes_t        stb,
  input  logic [31:0]        busWdata,
  output logic [LIMIT_W-1:0] countOut,
  output logic [LIMIT_W-1:0] limitOut,
  output logic               resetReq
);
  logic [LIMIT_W-1:0] cntQ, limQ;
  logic               firedQ, reqQ;
  logic [LIMIT_W:0]   cntNext;

  assign cntNext = {1'b0, cntQ} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limQ <= LIMIT_W'(INIT_TIMEOUT);
    end else if (stb.loadLimit) begin
      limQ <= busWdata[LIMIT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ   <= '0;
      firedQ <= 1'b0;
      reqQ   <= 1'b0;
    end else if (firedQ) begin
      if (tick) reqQ <= 1'b0;
    end else if (stb.refresh) begin
      cntQ <= '0;
    end else if (tick && stb.enable) begin
      cntQ <= cntNext[LIMIT_W-1:0];
      if (cntNext >= {1'b0, limQ}) begin
        firedQ <= 1'b1;
        reqQ   <= 1'b1;
      end
    end
  end

  assign countOut = cntQ;
  assign limitOut = limQ;
  assign resetReq = reqQ;

  // R3
  limit_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.loadLimit |=> $stable(limQ));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.enable && !stb.refresh) |=> $stable(cntQ));

  // R10
  fired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    firedQ |=> ($stable(cntQ) && firedQ));

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqQ && $past(reqQ) && tick) |=> !reqQ);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int LIMIT_W      = 17,
  parameter int WINDOW       = 256,
  parameter int INIT_TIMEOUT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              resetReq
);
  kwdStrobes_t        stb;
  logic [31:0]        ctrlWord;
  logic [LIMIT_W-1:0] countVal, limitVal;

  kwd_ctrl #(.ADDR_W(ADDR_W), .WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .stb(stb), .ctrlWord(ctrlWord)
  );

  kwd_datapath #(.LIMIT_W(LIMIT_W), .INIT_TIMEOUT(INIT_TIMEOUT)) u_dp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stb(stb), .busWdata(busWdata),
    .countOut(countVal), .limitOut(limitVal), .resetReq(resetReq)
  );

  always_comb begin
    case (busAddr)
      ADDR_W'(OFF_CTRL):  busRdata = ctrlWord;
      ADDR_W'(OFF_COUNT): busRdata = 32'(countVal);
      ADDR_W'(OFF_LIMIT): busRdata = 32'(limitVal);
      default:            busRdata = '0;
    endcase
  end
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        resetReq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [3:0] A_CTRL = 4'h0, A_CNT = 4'h4, A_LIM = 4'h8;

  keyed_watchdog uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .resetReq(resetReq)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic open16();
    wr(A_CNT, 32'h0000_C520); wr(A_CNT, 32'h0000_D928);
  endtask

  task automatic feed16();
    wr(A_CNT, 32'h0000_A602); wr(A_CNT, 32'h0000_B480);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    doReset();
    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h20);
    rd(A_CNT, v);  check("R1 count", v, 0);
    rd(A_LIM, v);  check("R1 limit", v, 1000);
    check("R1 req", {31'h0, resetReq}, 0);
    // R3 limit write while locked
    wr(A_LIM, 5); rd(A_LIM, v); check("R3 locked limit", v, 1000);
    wr(A_CTRL, 32'h80); rd(A_CTRL, v); check("R3 locked ctrl", v, 32'h20);
    // R4 16-bit unlock
    open16(); rd(A_CTRL, v); check("R4 unlocked bit", v, 32'h820);
    wr(A_LIM, 5); rd(A_LIM, v); check("R2 limit rw", v, 5);
    // R6 ctrl write closes window, sets done
    wr(A_CTRL, 32'hA0); rd(A_CTRL, v); check("R6 commit", v, 32'h4A0);
    // R7 broken and reversed sequences
    wr(A_CNT, 32'h0000_C520); wr(A_CNT, 32'h0000_1234); wr(A_CNT, 32'h0000_D928);
    rd(A_CTRL, v); check("R7 broken open", v, 32'h4A0);
    wr(A_CNT, 32'h0000_D928); wr(A_CNT, 32'h0000_C520); wr(A_CNT, 32'h0000_0001);
    rd(A_CTRL, v); check("R7 reversed open", v, 32'h4A0);
    // R9 counting and refresh; R7 wrong refresh half
    pulse(3); rd(A_CNT, v); check("R9 count", v, 3);
    wr(A_CNT, 32'h0000_A602); wr(A_CNT, 32'h0000_1111); wr(A_CNT, 32'h0000_B480);
    rd(A_CNT, v); check("R7 bad feed", v, 3);
    feed16(); rd(A_CNT, v); check("R9 feed", v, 0);
    // R9 disabled holds
    open16(); wr(A_CTRL, 32'h20); pulse(2);
    rd(A_CNT, v); check("R9 disabled hold", v, 0);
    rd(A_CTRL, v); check("R2 ctrl disabled", v, 32'h420);

    // R10 sweep over limits
    for (int t = 1; t <= 6; t++) begin
      doReset();
      open16(); wr(A_LIM, t); wr(A_CTRL, 32'hA0);
      pulse(t - 1);
      rd(A_CNT, v); check("R10 pre count", v, t - 1);
      check("R10 pre req", {31'h0, resetReq}, 0);
      pulse(1);
      check("R10 fire req", {31'h0, resetReq}, 1);
      rd(A_CNT, v); check("R10 fire count", v, t);
      pulse(1);
      check("R10 req drop", {31'h0, resetReq}, 0);
      feed16(); pulse(1);
      rd(A_CNT, v); check("R10 hold after feed", v, t);
    end

    // R6 window edges
    doReset();
    open16(); repeat (254) @(negedge clk); wr(A_LIM, 9);
    rd(A_LIM, v); check("R6 cycle 256", v, 9);
    open16(); repeat (255) @(negedge clk); wr(A_LIM, 11);
    rd(A_LIM, v); check("R6 cycle 257", v, 9);
    rd(A_CTRL, v); check("R6 window closed", v, 32'h20);

    // R5 32-bit key mode
    doReset();
    open16(); wr(A_CTRL, 32'h20A0);
    rd(A_CTRL, v); check("R5 mode set", v, 32'h24A0);
    open16(); rd(A_CTRL, v); check("R5 halves no open", v, 32'h24A0);
    pulse(2); feed16(); rd(A_CNT, v); check("R5 halves no feed", v, 2);
    wr(A_CNT, 32'hB480_A602); rd(A_CNT, v); check("R5 feed32", v, 0);
    wr(A_CNT, 32'hD928_C520); rd(A_CTRL, v); check("R5 open32", v, 32'h2CA0);

    // R8 freeze
    doReset();
    open16(); wr(A_CTRL, 32'h80);
    rd(A_CTRL, v); check("R8 commit", v, 32'h480);
    open16(); rd(A_CTRL, v); check("R8 no unlock", v, 32'h480);
    wr(A_LIM, 4); rd(A_LIM, v); check("R8 limit kept", v, 1000);
    wr(A_CTRL, 32'h0); rd(A_CTRL, v); check("R8 enable kept", v, 32'h480);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule